// File: doc/BRIEF.md
# UART Prioritized Interrupt Status Unit

This block collects the five interrupt causes of one serial channel (receive line error, receive data available, receive idle timeout, transmit holding register empty, and modem status change). It latches each cause when the cause starts, provided that the cause is enabled. It then selects the single most urgent enabled cause and shows it in a byte-wide status word. A host reads that word through a one-cycle read strobe. The same read acknowledges the cause that is currently shown and leaves every other latched cause in place. The next read therefore shows the next cause in the priority order.

The status word also reports whether the channel runs with its FIFOs enabled. The block drives an interrupt line that is high whenever any enabled cause is latched. The two receive-data causes follow the state of the FIFO: each one drops by itself when its condition goes away, so a host that drains the FIFO without reading status is not interrupted again.

Top module: `uart_irq_status`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, status_o reads 8'h01 and irq_o is 0, whatever fifo_mode_i is.
- R2: Priority runs from most to least urgent as: line error, receive ready, receive timeout, transmit empty, modem change. status_o shows only the most urgent enabled latched cause.
- R3: A cycle with rd_stb_i high clears only the cause that status_o shows in that cycle. Every other latched cause stays latched and is shown on a later read.
- R4: status_o[3:0] encodes the shown cause as follows: line error = 4'b0110, receive ready = 4'b0100, receive timeout = 4'b1100, transmit empty = 4'b0010, modem change = 4'b0000. When no cause is shown, the value is 4'b0001.
- R5: irq_o is the inverse of status_o[0]. It is 1 exactly when an enabled cause is latched.
- R6: status_o[7:6] both equal the value that fifo_mode_i had at the previous clock edge. status_o[5:4] always read 0.
- R7: A cause latches only on a 0-to-1 transition of its input, sampled at a clock edge, while its enable bit in src_en_i is 1. A transition that occurs while the enable bit is 0 is discarded.
- R8: Clearing an enable bit hides the latched cause at once without clearing it. Setting the bit again shows the cause again.
- R9: A more urgent cause that latches between two reads is shown on the next read, ahead of causes that were latched earlier.
- R10: A cause whose transition arrives in the same cycle as a read is not lost. This holds even when it is the cause being read.
- R11: A latched receive-ready or receive-timeout cause clears one cycle after its input falls to 0, without any read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fifo_mode_i | input | 1 | 1 when the channel FIFOs are enabled |
| src_en_i | input | 5 | Per-cause enables, bit 0 line error to bit 4 modem change, in priority order |
| line_err_i | input | 1 | Receive line error event |
| rx_ready_i | input | 1 | Receive FIFO at or above trigger level |
| rx_timeout_i | input | 1 | Receive character timeout condition |
| tx_empty_i | input | 1 | Transmit holding register empty event |
| modem_chg_i | input | 1 | Modem status change event |
| rd_stb_i | input | 1 | Status read strobe, one cycle per read |
| status_o | output | 8 | Status word |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a read that coincides with a new transition, either of a more urgent cause or of the cause being cleared. The result depends on the order in which causes were latched, and on the order in which they are masked and read. The bench sweeps all 32 subsets of simultaneously raised causes and drains each subset by repeated reads. It then places transitions exactly on read cycles, toggles enables around latched causes, and drops the receive conditions between reads. A bench-side model, built from the requirements, gives the expected status word after every edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 5;
  localparam int CODE_W = 4;
  localparam int STAT_W = 8;

  localparam int SRC_LINE = 0;
  localparam int SRC_RXRD = 1;
  localparam int SRC_RXTO = 2;
  localparam int SRC_TXE  = 3;
  localparam int SRC_MDM  = 4;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_NONE = 4'b0001;

  function automatic code_t code_of(input int idx);
    case (idx)
      SRC_LINE: code_of = 4'b0110;
      SRC_RXRD: code_of = 4'b0100;
      SRC_RXTO: code_of = 4'b1100;
      SRC_TXE:  code_of = 4'b0010;
      default:  code_of = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_pend.sv
module uart_irq_pend #(
  parameter int N = 5,
  parameter logic [N-1:0] LEVEL_CLR = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] ev_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic rise;
    logic drop;
    assign rise = ev_i[i] & ~ev_q[i];
    if (LEVEL_CLR[i]) begin : g_lvl
      assign drop = ack_i[i] | ~ev_i[i];
    end else begin : g_evt
      assign drop = ack_i[i];
    end
    always_comb begin
      pend_d[i] = pend_q[i] & ~drop;
      if (rise && en_i[i]) pend_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      pend_q <= '0;
    end else begin
      ev_q   <= ev_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  always_comb begin
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] grant_i,
  output code_t        code_o
);
  always_comb begin
    code_o = CODE_NONE;
    for (int i = 0; i < N; i++) begin
      if (grant_i[i]) code_o = code_of(i);
    end
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode_i,
  input  logic [NSRC-1:0]   src_en_i,
  input  logic              line_err_i,
  input  logic              rx_ready_i,
  input  logic              rx_timeout_i,
  input  logic              tx_empty_i,
  input  logic              modem_chg_i,
  input  logic              rd_stb_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  localparam logic [NSRC-1:0] LVL_MASK = (NSRC'(1) << SRC_RXRD) | (NSRC'(1) << SRC_RXTO);

  logic [NSRC-1:0] ev;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] grant;
  logic [NSRC-1:0] ack;
  logic            any;
  code_t           code;
  logic            fifo_q;
  logic            fifo_d;

  always_comb begin
    ev           = '0;
    ev[SRC_LINE] = line_err_i;
    ev[SRC_RXRD] = rx_ready_i;
    ev[SRC_RXTO] = rx_timeout_i;
    ev[SRC_TXE]  = tx_empty_i;
    ev[SRC_MDM]  = modem_chg_i;
  end

  uart_irq_pend #(.N(NSRC), .LEVEL_CLR(LVL_MASK)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   (ev),
    .en_i   (src_en_i),
    .ack_i  (ack),
    .pend_o (pend)
  );

  assign req = pend & src_en_i;

  uart_irq_prio #(.N(NSRC)) u_prio (
    .req_i   (req),
    .grant_o (grant),
    .any_o   (any)
  );

  uart_irq_encode #(.N(NSRC)) u_enc (
    .grant_i (grant),
    .code_o  (code)
  );

  assign ack = rd_stb_i ? grant : '0;

  always_comb begin
    fifo_d = fifo_q;
    fifo_d = fifo_mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fifo_q <= 1'b0;
    else        fifo_q <= fifo_d;
  end

  assign status_o = {fifo_q, fifo_q, 2'b00, code};
  assign irq_o    = any;
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk
  import uart_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rx_ready_i,
  input logic [STAT_W-1:0] status_o,
  input logic              irq_o,
  input logic [NSRC-1:0]   grant
);
  assert_irq_vs_bit0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ~status_o[0]);

  assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[5:4] == 2'b00 && status_o[7] == status_o[6]);

  assert_single_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_rx_level_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready_i |=> status_o[3:0] != 4'b0100);
endmodule

bind uart_irq_status uart_irq_status_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_ready_i (rx_ready_i),
  .status_o   (status_o),
  .irq_o      (irq_o),
  .grant      (grant)
);

// File: tb/uart_irq_status_tb.sv
module uart_irq_status_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo;
  logic [4:0] en;
  logic [4:0] ev;
  logic       rd;
  logic [7:0] status;
  logic       irq;

  int errors = 0;
  int checks = 0;

  logic [4:0] m_pend;
  logic [4:0] m_prev;
  logic       m_fifo;

  always #5 clk = ~clk;

  uart_irq_status u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_mode_i  (fifo),
    .src_en_i     (en),
    .line_err_i   (ev[0]),
    .rx_ready_i   (ev[1]),
    .rx_timeout_i (ev[2]),
    .tx_empty_i   (ev[3]),
    .modem_chg_i  (ev[4]),
    .rd_stb_i     (rd),
    .status_o     (status),
    .irq_o        (irq)
  );

  function automatic logic [4:0] top_of(input logic [4:0] v);
    for (int i = 0; i < 5; i++) if (v[i]) return 5'(1) << i;
    return 5'd0;
  endfunction

  function automatic logic [3:0] exp_code(input logic [4:0] v);
    logic [4:0] t;
    t = top_of(v);
    case (t)
      5'b00001: return 4'b0110;
      5'b00010: return 4'b0100;
      5'b00100: return 4'b1100;
      5'b01000: return 4'b0010;
      5'b10000: return 4'b0000;
      default:  return 4'b0001;
    endcase
  endfunction

  task automatic check(input string tag);
    logic [7:0] es;
    logic       ei;
    es = {m_fifo, m_fifo, 2'b00, exp_code(m_pend & en)};
    ei = |(m_pend & en);
    checks++;
    if (status !== es || irq !== ei) begin
      errors++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b", tag, status, irq, es, ei);
    end
  endtask

  // one clock edge; model advances with the inputs present at that edge
  task automatic tick();
    logic [4:0] clr;
    @(posedge clk);
    clr = rd ? top_of(m_pend & en) : 5'd0;
    clr[1] = clr[1] | ~ev[1];
    clr[2] = clr[2] | ~ev[2];
    m_pend = ((ev & ~m_prev) & en) | (m_pend & ~clr);
    m_prev = ev;
    m_fifo = fifo;
    #1;
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < 7; k++) begin
      check(tag);
      rd = 1'b1;
      tick();
      rd = 1'b0;
    end
    check(tag);
  endtask

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fifo = 1'b1; en = 5'h1f; ev = '0; rd = 1'b0;
    m_pend = '0; m_prev = '0; m_fifo = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 after release");
    tick();
    check("R6 fifo bits");

    // R2 R3 R4 R5: every subset of causes raised together, then drained
    for (int s = 0; s < 32; s++) begin
      ev = 5'(s); en = 5'h1f;
      tick();
      check("R7 latch R2 priority");
      drain("R2 R3 R4 R5 sweep");
      ev = '0;
      tick();
      check("R11 cleanup");
    end

    // R6: fifo mode off
    fifo = 1'b0; tick(); check("R6 fifo off");
    fifo = 1'b1; tick(); check("R6 fifo on");

    // R7: transition while disabled is discarded
    en = 5'b00000; ev = 5'b11001; tick();
    en = 5'h1f; tick(); check("R7 disabled edge dropped");
    ev = '0; tick();

    // R8: mask hides without clearing
    ev = 5'b01001; tick(); ev = '0; tick();
    en = 5'b11110; tick(); check("R8 masked line err");
    en = 5'b10110; tick(); check("R8 both masked");
    en = 5'h1f;    tick(); check("R8 unmasked again");
    drain("R8 drain");

    // R9: more urgent cause between reads
    ev = 5'b10000; tick(); ev = '0; tick(); check("R9 modem only");
    ev = 5'b00001; tick(); ev = '0; check("R9 line arrives");
    drain("R9 drain");

    // R10: arrival on the read cycle, other cause and same cause
    ev = 5'b01000; tick(); ev = '0; tick();
    rd = 1'b1; ev = 5'b00001; tick(); rd = 1'b0; ev = '0;
    check("R10 line kept across read");
    tick();
    rd = 1'b1; ev = 5'b00001; tick(); rd = 1'b0; ev = '0;
    check("R10 same cause re-raised on read");
    drain("R10 drain");

    // R11: receive conditions clear without a read
    ev = 5'b10110; tick(); check("R11 rx pending");
    ev = 5'b10100; tick(); check("R11 ready dropped");
    ev = 5'b10000; tick(); check("R11 timeout dropped");
    ev = '0; drain("R11 drain");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule